// File: doc/BRIEF.md
# Occupancy-Based Fetch Thread Chooser

This block decides which two hardware threads the instruction fetch unit serves in each cycle. It tracks eight threads. For each one it keeps a counter of that thread's instructions that have been fetched but not yet left the front half of the pipeline. Those are the instructions sitting in the fetch buffer, in decode, in rename or in an issue queue. A thread with few such instructions is draining quickly, so fetching for it pays off. Each cycle the chooser therefore grants the two eligible threads with the lowest counts. It does not rotate through the threads in turn.

The surrounding pipeline reports, per thread and per cycle, how many instructions were fetched and how many left the counted stages, either by issuing or by being squashed. It can also flush a thread's counter, and it marks which threads may be chosen at all. A thread is left out when it is inactive or stalled, for example on an instruction-cache miss. The two grants are registered. Each grant is a thread index with a valid flag. The current counters are also visible to the fetch unit.

Top module: `icount_fetch_chooser`

## Requirements
- R1: The chooser has 8 threads. Each cycle it registers two grants, slot 0 and slot 1. A grant computed at a clock edge uses the `eligible` input at that edge and the counters as they stood before that edge's update. The grant appears on the outputs just after that same edge.
- R2: At every clock edge, each thread's counter (its `CW`-bit field in `occupancy`) adds that thread's `fetch_add` field and subtracts its `drain_sub` field, both in the same cycle. Thread i owns bits `[i*IW +: IW]` of each update bus and bits `[i*CW +: CW]` of `occupancy`.
- R3: Slot 0 gets the eligible thread with the smallest count. Slot 1 gets the eligible thread with the next smallest count.
- R4: When counts are equal, the lower thread index wins. The two valid grants never name the same thread.
- R5: Only threads whose `eligible` bit is 1 are granted. With one eligible thread, only slot 0 is valid. With none, neither slot is valid. Slot 1 is never valid while slot 0 is invalid.
- R6: A 1 on a thread's `flush` bit sets that thread's counter to 0 at the next edge. This overrides any fetch or drain for that thread in the same cycle.
- R7: A counter never rises above `CNT_MAX` (default 40). A result that would be larger is held at `CNT_MAX`.
- R8: A counter never drops below zero. A result that would be negative is held at 0.
- R9: While `rst` is high at a clock edge, all counters become 0, both valid flags become 0 and both thread indices become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_add | input | NT*IW (24) | Per-thread number of instructions fetched this cycle |
| drain_sub | input | NT*IW (24) | Per-thread number of instructions issued or squashed this cycle |
| flush | input | NT (8) | Per-thread counter clear |
| eligible | input | NT (8) | Per-thread permission to be chosen |
| occupancy | output | NT*CW (48) | Current per-thread counters |
| pick0_id | output | TW (3) | Thread granted in slot 0 |
| pick0_vld | output | 1 | Slot 0 grant is valid |
| pick1_id | output | TW (3) | Thread granted in slot 1 |
| pick1_vld | output | 1 | Slot 1 grant is valid |

## Verification
The bench goes after equal counts, where a chooser that breaks ties by the higher index, or that grants one thread in both slots, would return the wrong pair. It tests eligibility masks with zero, one and two allowed threads. A design that ignored the mask would grant a stalled thread. A design that packed grants wrongly would raise slot 1 alone. It drives counters into both rails. An adder without clamping would wrap to a small count and then win priority it should not have. A flush that lost to a same-cycle fetch would leave a stale count. A long stretch of random traffic checks the lowest-two ordering against a model that updates its counts one edge later than it computes the grants.

// File: rtl/icf_pkg.sv
package icf_pkg;

  // Next value of one occupancy counter: flush wins, then add/subtract with
  // clamping to the range [0, max].
  function automatic int unsigned occ_next(input int unsigned cur,
                                           input int unsigned add,
                                           input int unsigned sub,
                                           input logic        clr,
                                           input int unsigned max);
    int unsigned up;
    if (clr) return 0;
    up = cur + add;
    if (up <= sub) return 0;
    if (up - sub > max) return max;
    return up - sub;
  endfunction

endpackage

// File: rtl/icf_counter.sv
module icf_counter #(
  parameter int IW      = 3,
  parameter int CNT_MAX = 40,
  parameter int CW      = $clog2(CNT_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] add,
  input  logic [IW-1:0] sub,
  input  logic          clr,
  output logic [CW-1:0] cnt
);
  import icf_pkg::*;

  logic [CW-1:0] cnt_q;
  int unsigned   nxt;

  always_comb begin
    nxt = occ_next(int'(cnt_q), int'(add), int'(sub), clr, CNT_MAX);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= CW'(nxt);
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/icf_select.sv
module icf_select #(
  parameter int NT = 8,
  parameter int CW = 6,
  parameter int TW = $clog2(NT)
) (
  input  logic [NT*CW-1:0] counts,
  input  logic [NT-1:0]    allow,
  output logic [TW-1:0]    sel0,
  output logic             ok0,
  output logic [TW-1:0]    sel1,
  output logic             ok1
);
  logic [CW-1:0] c [NT];

  for (genvar g = 0; g < NT; g++) begin : g_unpack
    assign c[g] = counts[g*CW +: CW];
  end

  // Strict less-than while scanning upward keeps the lowest index on ties.
  always_comb begin
    logic [CW-1:0] best0, best1;
    sel0  = '0;
    ok0   = 1'b0;
    best0 = '0;
    for (int i = 0; i < NT; i++) begin
      if (allow[i] && (!ok0 || c[i] < best0)) begin
        ok0   = 1'b1;
        sel0  = TW'(i);
        best0 = c[i];
      end
    end
    sel1  = '0;
    ok1   = 1'b0;
    best1 = '0;
    for (int i = 0; i < NT; i++) begin
      if (allow[i] && ok0 && (TW'(i) != sel0) && (!ok1 || c[i] < best1)) begin
        ok1   = 1'b1;
        sel1  = TW'(i);
        best1 = c[i];
      end
    end
  end
endmodule

// File: rtl/icount_fetch_chooser.sv
module icount_fetch_chooser #(
  parameter int NT      = 8,
  parameter int IW      = 3,
  parameter int CNT_MAX = 40,
  localparam int CW     = $clog2(CNT_MAX + 1),
  localparam int TW     = $clog2(NT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NT*IW-1:0] fetch_add,
  input  logic [NT*IW-1:0] drain_sub,
  input  logic [NT-1:0]    flush,
  input  logic [NT-1:0]    eligible,
  output logic [NT*CW-1:0] occupancy,
  output logic [TW-1:0]    pick0_id,
  output logic             pick0_vld,
  output logic [TW-1:0]    pick1_id,
  output logic             pick1_vld
);
  logic [NT*CW-1:0] occ;
  logic [TW-1:0]    s0, s1;
  logic             v0, v1;

  for (genvar g = 0; g < NT; g++) begin : g_thread
    icf_counter #(.IW(IW), .CNT_MAX(CNT_MAX), .CW(CW)) u_cnt (
      .clk (clk),
      .rst (rst),
      .add (fetch_add[g*IW +: IW]),
      .sub (drain_sub[g*IW +: IW]),
      .clr (flush[g]),
      .cnt (occ[g*CW +: CW])
    );
  end

  icf_select #(.NT(NT), .CW(CW), .TW(TW)) u_sel (
    .counts (occ),
    .allow  (eligible),
    .sel0   (s0),
    .ok0    (v0),
    .sel1   (s1),
    .ok1    (v1)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pick0_id  <= '0;
      pick0_vld <= 1'b0;
      pick1_id  <= '0;
      pick1_vld <= 1'b0;
    end else begin
      pick0_id  <= s0;
      pick0_vld <= v0;
      pick1_id  <= s1;
      pick1_vld <= v1;
    end
  end

  assign occupancy = occ;
endmodule

// File: rtl/icf_checker.sv
module icf_checker #(
  parameter int NT      = 8,
  parameter int IW      = 3,
  parameter int CNT_MAX = 40,
  parameter int CW      = 6,
  parameter int TW      = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [NT*IW-1:0] fetch_add,
  input logic [NT*IW-1:0] drain_sub,
  input logic [NT-1:0]    flush,
  input logic [NT-1:0]    eligible,
  input logic [NT*CW-1:0] occupancy,
  input logic [TW-1:0]    pick0_id,
  input logic             pick0_vld,
  input logic [TW-1:0]    pick1_id,
  input logic             pick1_vld
);
  logic [NT*CW-1:0] occ_d;
  logic [NT-1:0]    elig_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      occ_d  <= '0;
      elig_d <= '0;
    end else begin
      occ_d  <= occupancy;
      elig_d <= eligible;
    end
  end

  p_distinct_r4: assert property (@(posedge clk) disable iff (rst)
    (pick0_vld && pick1_vld) |-> (pick0_id != pick1_id));

  p_slot_order_r5: assert property (@(posedge clk) disable iff (rst)
    pick1_vld |-> pick0_vld);

  p_grant_eligible_r5: assert property (@(posedge clk) disable iff (rst)
    pick0_vld |-> elig_d[pick0_id]);

  p_lowest_first_r3: assert property (@(posedge clk) disable iff (rst)
    (pick0_vld && pick1_vld) |->
      (occ_d[pick0_id*CW +: CW] <= occ_d[pick1_id*CW +: CW]));

  p_hold_max_r7: assert property (@(posedge clk) disable iff (rst)
    (occupancy[CW-1:0] == CW'(CNT_MAX) && !flush[0] &&
     fetch_add[IW-1:0] >= drain_sub[IW-1:0]) |=> (occupancy[CW-1:0] == CW'(CNT_MAX)));

  for (genvar g = 0; g < NT; g++) begin : g_fl
    p_flush_clears_r6: assert property (@(posedge clk) disable iff (rst)
      flush[g] |=> (occupancy[g*CW +: CW] == '0));
  end
endmodule

bind icount_fetch_chooser icf_checker #(
  .NT(NT), .IW(IW), .CNT_MAX(CNT_MAX), .CW(CW), .TW(TW)
) u_icf_checker (
  .clk(clk), .rst(rst), .fetch_add(fetch_add), .drain_sub(drain_sub),
  .flush(flush), .eligible(eligible), .occupancy(occupancy),
  .pick0_id(pick0_id), .pick0_vld(pick0_vld),
  .pick1_id(pick1_id), .pick1_vld(pick1_vld)
);

// File: tb/test_icount_fetch_chooser.sv
module test_icount_fetch_chooser;
  localparam int NT = 8, IW = 3, CNT_MAX = 40, CW = 6, TW = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NT*IW-1:0] fetch_add = '0;
  logic [NT*IW-1:0] drain_sub = '0;
  logic [NT-1:0]    flush = '0;
  logic [NT-1:0]    eligible = '0;
  logic [NT*CW-1:0] occupancy;
  logic [TW-1:0]    pick0_id, pick1_id;
  logic             pick0_vld, pick1_vld;

  always #2 clk = ~clk;  // 250 MHz

  icount_fetch_chooser i_icount_fetch_chooser (
    .clk(clk), .rst(rst), .fetch_add(fetch_add), .drain_sub(drain_sub),
    .flush(flush), .eligible(eligible), .occupancy(occupancy),
    .pick0_id(pick0_id), .pick0_vld(pick0_vld),
    .pick1_id(pick1_id), .pick1_vld(pick1_vld)
  );

  typedef struct {
    int    p0, p1;
    bit    v0, v1;
    int    cnt[NT];
    string tag;
  } exp_t;

  exp_t q[$];
  int   m_cnt[NT];
  int   n_checks = 0, n_fail = 0;
  bit   done = 0;

  // Driver: applies one cycle of stimulus and queues the expected result.
  task automatic step(input int add[NT], input int sub[NT],
                      input logic [NT-1:0] fl, input logic [NT-1:0] el,
                      input string tag);
    exp_t e;
    int b0, b1;
    @(negedge clk);
    for (int i = 0; i < NT; i++) begin
      fetch_add[i*IW +: IW] = IW'(add[i]);
      drain_sub[i*IW +: IW] = IW'(sub[i]);
    end
    flush = fl;
    eligible = el;
    e.v0 = 0; e.v1 = 0; e.p0 = 0; e.p1 = 0; b0 = 0; b1 = 0;
    for (int i = 0; i < NT; i++)
      if (el[i] && (!e.v0 || m_cnt[i] < b0)) begin e.v0 = 1; e.p0 = i; b0 = m_cnt[i]; end
    for (int i = 0; i < NT; i++)
      if (el[i] && e.v0 && i != e.p0 && (!e.v1 || m_cnt[i] < b1)) begin
        e.v1 = 1; e.p1 = i; b1 = m_cnt[i];
      end
    for (int i = 0; i < NT; i++) begin
      int t;
      t = m_cnt[i] + add[i] - sub[i];
      if (fl[i]) t = 0;
      if (t < 0) t = 0;
      if (t > CNT_MAX) t = CNT_MAX;
      m_cnt[i] = t;
      e.cnt[i] = t;
    end
    e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compares just after the edge that consumed the queued stimulus.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        bit ok;
        e = q.pop_front();
        n_checks++;
        ok = (pick0_vld == e.v0) && (pick1_vld == e.v1) &&
             (!e.v0 || pick0_id == TW'(e.p0)) && (!e.v1 || pick1_id == TW'(e.p1));
        if (!ok) begin
          n_fail++;
          $display("FAIL %s grants: got v0=%0d id0=%0d v1=%0d id1=%0d, expected v0=%0d id0=%0d v1=%0d id1=%0d",
                   e.tag, pick0_vld, pick0_id, pick1_vld, pick1_id, e.v0, e.p0, e.v1, e.p1);
        end
        for (int i = 0; i < NT; i++) begin
          n_checks++;
          if (occupancy[i*CW +: CW] != CW'(e.cnt[i])) begin
            n_fail++;
            $display("FAIL %s counter %0d: got %0d expected %0d",
                     e.tag, i, occupancy[i*CW +: CW], e.cnt[i]);
          end
        end
      end
    end
  end

  function automatic void summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endfunction

  initial begin
    #400000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int z[NT], a[NT], s[NT];
    z = '{default: 0};
    for (int i = 0; i < NT; i++) m_cnt[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    n_checks++;
    if (pick0_vld || pick1_vld || pick0_id != 0 || pick1_id != 0 || occupancy != '0) begin
      n_fail++;
      $display("FAIL R9 reset: got v0=%0d v1=%0d id0=%0d id1=%0d occ=%h, expected all 0",
               pick0_vld, pick1_vld, pick0_id, pick1_id, occupancy);
    end
    @(negedge clk);
    rst = 1'b0;

    // R1/R4: all equal, lowest two indices win
    step(z, z, '0, 8'hFF, "R4");
    // R2: load distinct counts
    a = '{5, 3, 2, 6, 4, 7, 1, 6};
    step(a, z, '0, 8'hFF, "R2");
    // R3: smallest two are thread 6 (1) and 2 (2)
    step(z, z, '0, 8'hFF, "R3");
    // R2: add and subtract together
    a = '{1, 0, 3, 0, 0, 0, 4, 0};
    s = '{3, 1, 0, 0, 2, 0, 0, 1};
    step(a, s, '0, 8'hFF, "R2");
    // R3: counts now 3,2,5,6,2,7,5,5 -> thread 1 then 4 (tie, R4)
    step(z, z, '0, 8'hFF, "R3");
    // R5: mask excludes low threads
    step(z, z, '0, 8'b1010_1000, "R5");
    step(z, z, '0, 8'b0100_0000, "R5");
    step(z, z, '0, 8'h00, "R5");
    // R6: flush thread 5 while fetching for it
    a = '{0, 0, 0, 0, 0, 7, 0, 0};
    step(a, z, 8'b0010_0000, 8'hFF, "R6");
    step(z, z, '0, 8'hFF, "R6");
    // R7: drive thread 3 to the rail and hold it there
    a = '{0, 0, 0, 7, 0, 0, 0, 0};
    for (int k = 0; k < 7; k++) step(a, z, '0, 8'hFF, "R7");
    s = '{0, 0, 0, 2, 0, 0, 0, 0};
    step(a, s, '0, 8'hFF, "R7");
    // R8: over-drain threads 1 and 4
    s = '{0, 7, 0, 0, 7, 0, 0, 0};
    step(z, s, '0, 8'hFF, "R8");
    step(z, s, '0, 8'b0001_0010, "R8");
    // R1/R3: random traffic
    for (int k = 0; k < 300; k++) begin
      logic [NT-1:0] fl, el;
      for (int i = 0; i < NT; i++) begin
        a[i] = $urandom_range(0, 7);
        s[i] = $urandom_range(0, 6);
      end
      fl = ($urandom_range(0, 9) == 0) ? NT'(1 << $urandom_range(0, NT - 1)) : '0;
      el = NT'($urandom);
      step(a, s, fl, el, "R3");
    end
    step(z, z, '0, 8'hFF, "R1");
    repeat (3) @(posedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule